// File: doc/BRIEF.md
# Interrupt Status and Request Logic for a Card Socket

This block collects the interrupt sources of a card-socket controller into one 8-bit status register and drives a single interrupt request pin. It has two kinds of source. The first is five live card lines: card detect, write protect, ready, and two battery indications. Each line passes through a two-flop synchroniser, and any edge on an unmasked line flags a card status change. The second is single-cycle event pulses for an error, a program-timer expiry, an interlock change, a stop-CPU request and an I/O check.

Host writes to the status register are qualified by the two low bits of the written byte. Those bits are never stored. They select one of four operations on the upper six bits:
- set the bits written as one;
- clear the bits written as one;
- load the field as written;
- do nothing.

A separate enable register decides which of the four maskable status bits raise the request. It also picks the pin's electrical mode: high impedance, active-low open drain, active-low push-pull, or active-high push-pull.

The request path is a two-state machine, REQ_QUIET and REQ_RAISED. On each clock it takes RAISE when any enabled status bit is set, and DROP when none is. The pad enable and pad level are decoded from this state and the selected mode.

Top module: `irq_status_ctrl`

## Requirements
- R1: An event pulse held for one cycle sets its status bit at the next rising edge: I/O check sets bit 7, error bit 5, program timer bit 4, interlock bit 3, stop-CPU bit 2.
- R2: A status write whose bits 1:0 are 2'b10 sets every status bit in 7:2 that is written as one and leaves the others unchanged.
- R3: A status write whose bits 1:0 are 2'b01 clears every status bit in 7:2 that is written as one and leaves the others unchanged.
- R4: A status write whose bits 1:0 are 2'b11 loads bits 7:2 as written.
- R5: A status write whose bits 1:0 are 2'b00 has no effect. Status reads (rd_sel_i = 0) always return zero in bits 1:0.
- R6: A write to the enable register (wr_sel_i = 1) stores bits 6:3 and 1:0 as written. Enable bits 7 and 2 always read zero.
- R7: The request is pending when any of status bits 6:3 is set together with the enable bit at the same position. Status bits 7 and 2 never raise it. The request state follows the pending condition one clock later.
- R8: Enable bits 1:0 select the pin mode. In mode 0 irq_oe_o is 0. In mode 1 irq_oe_o equals the request and irq_out_o is 0. In mode 2 irq_oe_o is 1 and irq_out_o is the inverted request. In mode 3 irq_oe_o is 1 and irq_out_o is the request.
- R9: The card inputs are ordered card_stat_i[4..0] = card detect, write protect, ready, battery 2, battery 1. Any rising or falling edge on an unmasked input sets status bit 6. The bit reads set after the third rising clock edge following the input change, and not after the second.
- R10: When src_mask_i[k] is 1, an edge on card_stat_i[k] does not set status bit 6. Clearing the mask afterwards does not replay that edge.
- R11: An event or a detected change that arrives in the same cycle as a host clear or load of its bit leaves the bit set.
- R12: After reset the status register, the enable register and both pin outputs are zero (pin mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_stat_i | input | NSRC | Live card lines: detect, write protect, ready, battery 2, battery 1 (MSB first) |
| src_mask_i | input | NSRC | Per-line change suppress, same order as card_stat_i |
| err_evt_i | input | 1 | Error event pulse |
| ptmr_evt_i | input | 1 | Program-timer expiry pulse |
| lock_evt_i | input | 1 | Interlock change pulse |
| halt_evt_i | input | 1 | Stop-CPU request pulse |
| iochk_evt_i | input | 1 | I/O check pulse |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 enable |
| wr_data_i | input | 8 | Host write data |
| rd_sel_i | input | 1 | Read source: 0 status, 1 enable |
| rd_data_o | output | 8 | Read data of the selected register |
| irq_oe_o | output | 1 | Request pad output enable |
| irq_out_o | output | 1 | Request pad level when enabled |

## Verification
The bench checks the exact cycle at which a line edge becomes visible. A synchroniser one stage too short or too long shows bit 6 either at the second edge or missing at the third. It drives a host clear and an event in the same cycle. A design that gives the host priority would lose the event and read bit 5 as zero. It writes qualifier 2'b00 with ones in the field and later loads a value with ones in bits 1:0. A decoder that treats 00 as a load would wipe the register, and a design that stores the qualifier bits would read them back. It walks all four pin modes with the request both on and off, and raises bits 7 and 2 with every gate open. A swapped mode code or a wider gate would drive the wrong pad level.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int FLD_LO   = 2;
    localparam int FLD_W    = STAT_W - FLD_LO;

    localparam int IOCHK_BIT = 7;
    localparam int CHG_BIT   = 6;
    localparam int ERR_BIT   = 5;
    localparam int PTMR_BIT  = 4;
    localparam int LOCK_BIT  = 3;
    localparam int HALT_BIT  = 2;

    localparam int GATE_HI = 6;
    localparam int GATE_LO = 3;

    localparam logic [STAT_W-1:0] ENA_KEEP = 8'b0111_1011;

    typedef enum logic [1:0] {
        WOP_NONE = 2'b00,
        WOP_CLR  = 2'b01,
        WOP_SET  = 2'b10,
        WOP_LOAD = 2'b11
    } wop_e;

    typedef enum logic [1:0] {
        PIN_HIZ     = 2'd0,
        PIN_OD_LOW  = 2'd1,
        PIN_PP_LOW  = 2'd2,
        PIN_PP_HIGH = 2'd3
    } pin_mode_e;

    typedef enum logic {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

endpackage

// File: rtl/irq_chg_detect.sv
module irq_chg_detect #(
    parameter int NSRC        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lines_i,
    input  logic [NSRC-1:0] mask_i,
    output logic            chg_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][NSRC-1:0] sync_q;
    logic [NSRC-1:0]                  prev_q;
    logic [NSRC-1:0]                  edge_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= lines_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // One edge detector per monitored line, masked individually
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign edge_w[g] = (sync_q[LAST][g] ^ prev_q[g]) & ~mask_i[g];
    end

    assign chg_o = |edge_w;

endmodule

// File: rtl/irq_wr_qual.sv
module irq_wr_qual
    import irq_stat_pkg::*;
(
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [1:0] qual_i,
    output wop_e       op_o
);

    always_comb begin
        if (wr_en_i && !wr_sel_i) begin
            op_o = wop_e'(qual_i);
        end else begin
            op_o = WOP_NONE;
        end
    end

endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wop_e              op_i,
    input  logic [FLD_W-1:0]  wfld_i,
    input  logic [FLD_W-1:0]  evt_i,
    output logic [STAT_W-1:0] stat_o
);

    logic [FLD_W-1:0] fld_q;
    logic [FLD_W-1:0] host_v;
    logic [FLD_W-1:0] fld_d;

    always_comb begin
        host_v = fld_q;
        unique case (op_i)
            WOP_NONE: host_v = fld_q;
            WOP_SET:  host_v = fld_q | wfld_i;
            WOP_CLR:  host_v = fld_q & ~wfld_i;
            WOP_LOAD: host_v = wfld_i;
        endcase
        // Hardware events win over any host operation in the same cycle
        fld_d = host_v | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign stat_o = {fld_q, {FLD_LO{1'b0}}};

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend_i,
    input  logic [1:0] mode_i,
    output logic       oe_o,
    output logic       out_o
);

    req_state_e state_q;
    req_state_e state_d;
    pin_mode_e  mode_w;
    logic       req_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (pend_i)  state_d = REQ_RAISED;
            REQ_RAISED: if (!pend_i) state_d = REQ_QUIET;
        endcase
    end

    assign mode_w = pin_mode_e'(mode_i);
    assign req_w  = (state_q == REQ_RAISED);

    always_comb begin
        oe_o  = 1'b0;
        out_o = 1'b0;
        unique case (mode_w)
            PIN_HIZ: begin
                oe_o  = 1'b0;
                out_o = 1'b0;
            end
            PIN_OD_LOW: begin
                oe_o  = req_w;
                out_o = 1'b0;
            end
            PIN_PP_LOW: begin
                oe_o  = 1'b1;
                out_o = ~req_w;
            end
            PIN_PP_HIGH: begin
                oe_o  = 1'b1;
                out_o = req_w;
            end
        endcase
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int NSRC        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   card_stat_i,
    input  logic [NSRC-1:0]   src_mask_i,
    input  logic              err_evt_i,
    input  logic              ptmr_evt_i,
    input  logic              lock_evt_i,
    input  logic              halt_evt_i,
    input  logic              iochk_evt_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              irq_oe_o,
    output logic              irq_out_o
);

    logic              chg_w;
    wop_e              op_w;
    logic [STAT_W-1:0] evt_w;
    logic [STAT_W-1:0] stat_w;
    logic [STAT_W-1:0] ena_q;
    logic              pend_w;

    irq_chg_detect #(
        .NSRC        (NSRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (card_stat_i),
        .mask_i  (src_mask_i),
        .chg_o   (chg_w)
    );

    irq_wr_qual u_qual (
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .qual_i   (wr_data_i[FLD_LO-1:0]),
        .op_o     (op_w)
    );

    always_comb begin
        evt_w            = '0;
        evt_w[IOCHK_BIT] = iochk_evt_i;
        evt_w[CHG_BIT]   = chg_w;
        evt_w[ERR_BIT]   = err_evt_i;
        evt_w[PTMR_BIT]  = ptmr_evt_i;
        evt_w[LOCK_BIT]  = lock_evt_i;
        evt_w[HALT_BIT]  = halt_evt_i;
    end

    irq_stat_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_w),
        .wfld_i (wr_data_i[STAT_W-1:FLD_LO]),
        .evt_i  (evt_w[STAT_W-1:FLD_LO]),
        .stat_o (stat_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (wr_en_i && wr_sel_i) begin
            ena_q <= wr_data_i & ENA_KEEP;
        end
    end

    assign pend_w = |(stat_w[GATE_HI:GATE_LO] & ena_q[GATE_HI:GATE_LO]);

    irq_pin_fsm u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_w),
        .mode_i (ena_q[1:0]),
        .oe_o   (irq_oe_o),
        .out_o  (irq_out_o)
    );

    assign rd_data_o = rd_sel_i ? ena_q : stat_w;

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic       wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic       err_evt_i,
    input logic       ptmr_evt_i,
    input logic       lock_evt_i,
    input logic       halt_evt_i,
    input logic       iochk_evt_i,
    input logic       chg_v,
    input logic [7:0] stat_v,
    input logic [7:0] ena_v,
    input logic       rd_sel_i,
    input logic [7:0] rd_data_o,
    input logic       irq_oe_o,
    input logic       irq_out_o
);

    logic quiet_w;
    logic sw_w;
    logic pend_w;

    assign quiet_w = !(err_evt_i || ptmr_evt_i || lock_evt_i ||
                       halt_evt_i || iochk_evt_i || chg_v);
    assign sw_w    = wr_en_i && !wr_sel_i;
    assign pend_w  = |(stat_v[6:3] & ena_v[6:3]);

    // R1
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i |=> stat_v[5]);

    // R2
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_w && wr_data_i[1:0] == 2'b10) |=>
            ((stat_v[7:2] & $past(wr_data_i[7:2])) == $past(wr_data_i[7:2])));

    // R3
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_w && wr_data_i[1:0] == 2'b01 && quiet_w) |=>
            ((stat_v[7:2] & $past(wr_data_i[7:2])) == 6'd0));

    // R5
    noop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_w && wr_data_i[1:0] == 2'b00 && quiet_w) |=> $stable(stat_v));

    // R5
    rd_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel_i |-> (rd_data_o[1:0] == 2'b00));

    // R6
    ena_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_v[7] == 1'b0) && (ena_v[2] == 1'b0));

    // R8
    hiz_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_v[1:0] == 2'd0) |-> !irq_oe_o);

    // R8
    od_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_v[1:0] == 2'd1) |-> !irq_out_o);

    // R7
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w |=> (ena_v[1:0] != 2'd3 || (irq_oe_o && irq_out_o)));

endmodule

bind irq_status_ctrl irq_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .err_evt_i   (err_evt_i),
    .ptmr_evt_i  (ptmr_evt_i),
    .lock_evt_i  (lock_evt_i),
    .halt_evt_i  (halt_evt_i),
    .iochk_evt_i (iochk_evt_i),
    .chg_v       (chg_w),
    .stat_v      (stat_w),
    .ena_v       (ena_q),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .irq_oe_o    (irq_oe_o),
    .irq_out_o   (irq_out_o)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;

    localparam int CYC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] card_stat = '0;
    logic [4:0] src_mask = '0;
    logic       err_evt = 0, ptmr_evt = 0, lock_evt = 0, halt_evt = 0, iochk_evt = 0;
    logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_oe, irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CYC/2) clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .card_stat_i(card_stat), .src_mask_i(src_mask),
        .err_evt_i(err_evt), .ptmr_evt_i(ptmr_evt), .lock_evt_i(lock_evt),
        .halt_evt_i(halt_evt), .iochk_evt_i(iochk_evt), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .irq_oe_o(irq_oe), .irq_out_o(irq_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_pin(input string req, input logic oe, input logic out);
        #1;
        chk(req, {6'd0, irq_oe, irq_out}, {6'd0, oe, out});
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(0, v); chk("R12 status", v, 8'h00);
        rd(1, v); chk("R12 enable", v, 8'h00);
        chk_pin("R12 pins", 1'b0, 1'b0);
    endtask

    task automatic t_qualified();
        logic [7:0] v;
        wr(0, 8'h62); rd(0, v); chk("R2 set", v, 8'h60);
        wr(0, 8'h41); rd(0, v); chk("R3 clear", v, 8'h20);
        wr(0, 8'h9F); rd(0, v); chk("R4 load", v, 8'h9C);
        wr(0, 8'hFC); rd(0, v); chk("R5 no qualifier", v, 8'h9C);
        wr(0, 8'hFD); rd(0, v); chk("R3 clear all", v, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(1, 8'hFF); rd(1, v); chk("R6 reserved", v, 8'h7B);
        wr(1, 8'h00); rd(1, v); chk("R6 zero", v, 8'h00);
    endtask

    task automatic t_pins();
        wr(0, 8'h22);
        wr(1, 8'h23); @(negedge clk); chk_pin("R8 mode3 on", 1, 1);
        wr(1, 8'h22); @(negedge clk); chk_pin("R8 mode2 on", 1, 0);
        wr(1, 8'h21); @(negedge clk); chk_pin("R8 mode1 on", 1, 0);
        wr(1, 8'h20); @(negedge clk); chk_pin("R8 mode0 on", 0, 0);
        wr(1, 8'h22);
        wr(0, 8'h21); @(negedge clk); chk_pin("R8 mode2 off", 1, 1);
        wr(1, 8'h21); @(negedge clk); chk_pin("R8 mode1 off", 0, 0);
        wr(0, 8'h86);
        wr(1, 8'h7B); @(negedge clk); chk_pin("R7 bits7_2 no request", 1, 0);
        wr(0, 8'h85);
        wr(1, 8'h00);
    endtask

    task automatic t_change();
        logic [7:0] v;
        wr(1, 8'h43);
        @(negedge clk); card_stat[4] = 1'b1;
        cycles(2); rd(0, v); chk("R9 not at second edge", v, 8'h00);
        cycles(1); rd(0, v); chk("R9 at third edge", v, 8'h40);
        cycles(1); chk_pin("R7 request after change", 1, 1);
        wr(0, 8'h41);
        card_stat[2] = 1'b1; cycles(4); rd(0, v); chk("R9 ready rising", v, 8'h40);
        wr(0, 8'h41);
        card_stat[2] = 1'b0; cycles(4); rd(0, v); chk("R9 ready falling", v, 8'h40);
        wr(0, 8'h41);
        card_stat[0] = 1'b1; cycles(4); rd(0, v); chk("R9 battery 1", v, 8'h40);
        wr(0, 8'h41);
        wr(1, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        src_mask[3] = 1'b1;
        card_stat[3] = 1'b1; cycles(5); rd(0, v); chk("R10 masked", v, 8'h00);
        src_mask[3] = 1'b0; cycles(4); rd(0, v); chk("R10 no replay", v, 8'h00);
        card_stat[3] = 1'b0; cycles(4); rd(0, v); chk("R10 unmasked", v, 8'h40);
        wr(0, 8'h41);
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        case (b)
            7: iochk_evt = 1; 5: err_evt = 1; 4: ptmr_evt = 1;
            3: lock_evt = 1;  default: halt_evt = 1;
        endcase
        @(negedge clk);
        {iochk_evt, err_evt, ptmr_evt, lock_evt, halt_evt} = '0;
    endtask

    task automatic t_events();
        logic [7:0] v;
        pulse(7); rd(0, v); chk("R1 io check bit7", v, 8'h80); wr(0, 8'hFD);
        pulse(5); rd(0, v); chk("R1 error bit5", v, 8'h20); wr(0, 8'hFD);
        pulse(4); rd(0, v); chk("R1 timer bit4", v, 8'h10); wr(0, 8'hFD);
        pulse(3); rd(0, v); chk("R1 interlock bit3", v, 8'h08); wr(0, 8'hFD);
        pulse(2); rd(0, v); chk("R1 stop bit2", v, 8'h04); wr(0, 8'hFD);
    endtask

    task automatic t_race();
        logic [7:0] v;
        wr(0, 8'h22);
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_data = 8'h21; err_evt = 1;
        @(negedge clk);
        wr_en = 0; wr_data = '0; err_evt = 0;
        rd(0, v); chk("R11 clear vs event", v, 8'h20);
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_data = 8'h03; ptmr_evt = 1;
        @(negedge clk);
        wr_en = 0; wr_data = '0; ptmr_evt = 0;
        rd(0, v); chk("R11 load vs event", v, 8'h10);
        wr(0, 8'hFD);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_qualified();
        t_enable();
        t_pins();
        t_change();
        t_mask();
        t_events();
        t_race();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CYC * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule